// File: doc/BRIEF.md
# Dual-CPU Interrupt Request Controller

This block latches interrupt requests for two CPUs that share one adapter. Four sources are common to both CPUs: a reset-button request, a vertical-blank request, a horizontal-blank request and a PWM request. Each CPU also has a command request of its own, which a host processor raises by writing a control byte. A source stays pending until a CPU writes to the clear address assigned to it. The command clear acts only on the CPU that performs the write.

Each CPU has its own register port. The index of the port selects the per-CPU state: the CPU's 4-bit mask and its command request. A write to offset 0x00 loads the mask. A read of offset 0x00 returns the mask together with adapter status bits. Each CPU gets one interrupt line. It is the OR of all pending sources that its mask enables. The reset-button source is always enabled.

Each source is held by a two-state machine, `src_state_e`, which has two states:
- `SRC_IDLE`: no request is held.
- `SRC_PEND`: a request is held.

It has these transitions:
- `SRC_IDLE -> SRC_PEND` on a set pulse.
- `SRC_PEND -> SRC_IDLE` on a clear strobe, when no set pulse arrives in the same cycle.
- Every other case holds the current state.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, nothing is pending and both masks are zero. Both `cpu_irq` bits are 0, and a read of offset 0x00 returns 0x0200 when `adapter_fm` is 0.
- R2: A host write sets CPU i's command request when bit i of `host_data` is 1. Bit 0 selects CPU 0 (master) and bit 1 selects CPU 1 (slave). Bits 7:2 have no effect.
- R3: Raising a command request that is already pending leaves it pending. A single clear write then removes it.
- R4: A CPU write clears one shared source at each of these offsets: 0x14 clears reset-button, 0x16 clears vertical, 0x18 clears horizontal and 0x1C clears PWM. A write from either CPU clears the source for both CPUs.
- R5: A CPU write to offset 0x1A clears only that CPU's own command request.
- R6: A CPU write to offset 0x00 loads that CPU's mask from data bits 3:0. Data bits 15:4 are ignored, and the other CPU's mask is unchanged.
- R7: A read of offset 0x00 returns `adapter_fm` in bit 15, a constant 1 in bit 9 and the mask in bits 3:0, with all other bits 0. A read of any other offset returns 0. The read data is combinational on the address.
- R8: A CPU's `cpu_irq` is high when any of the following holds:
  - reset-button is pending;
  - PWM is pending and mask bit 0 is set;
  - that CPU's command request is pending and mask bit 1 is set;
  - horizontal is pending and mask bit 2 is set;
  - vertical is pending and mask bit 3 is set.
- R9: A set pulse in the same cycle as a clear write for the same source leaves that source pending.
- R10: A one-cycle pulse on `src_set` bit k sets that source on the next edge, and it stays pending until it is cleared. The bits are 0 = reset-button, 1 = vertical, 2 = horizontal and 3 = PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command-raise byte |
| host_data | input | 8 | Command-raise byte; bit i targets CPU i |
| adapter_fm | input | 1 | Adapter FM status bit, shown in readback |
| src_set | input | 4 | Set pulses for the shared sources |
| cpu_wr | input | NCPU | Write strobe per CPU port |
| cpu_addr | input | NCPU*AW | Byte offset per CPU port, CPU 0 in the low slice |
| cpu_wdata | input | NCPU*DW | Write data per CPU port |
| cpu_rdata | output | NCPU*DW | Read data per CPU port |
| cpu_irq | output | NCPU | Interrupt request per CPU |

## Verification
A source machine stuck in `SRC_PEND` shows on `cpu_irq` as soon as that CPU's mask enables the source, at the latest one cycle after the mask is written. A stuck reset-button source shows at once, because nothing masks it. A clear or a command raise routed to the wrong CPU shows at the next sample of the other CPU's line. A corrupted mask appears both in the readback at offset 0x00 and in the interrupt line, one cycle after the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC   = 4;
    localparam int MASK_W = 4;

    // shared source indices
    localparam int SRC_VRES = 0;
    localparam int SRC_VBL  = 1;
    localparam int SRC_HBL  = 2;
    localparam int SRC_PWM  = 3;

    // mask bit positions
    localparam int MB_PWM = 0;
    localparam int MB_CMD = 1;
    localparam int MB_HBL = 2;
    localparam int MB_VBL = 3;

    // readback bit positions
    localparam int RB_FM_BIT  = 15;
    localparam int RB_EN_BIT  = 9;

    // register offsets
    localparam int OFF_MASK    = 'h00;
    localparam int OFF_CLR_CMD = 'h1A;
    localparam int CLR_OFF [NSRC] = '{'h14, 'h16, 'h18, 'h1C};

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_e;

endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    src_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (set_i) state_d = SRC_PEND;
            SRC_PEND: if (clr_i && !set_i) state_d = SRC_IDLE;
            default:  state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == SRC_PEND);
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(pend_o));

endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
    import irqc_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            fm,
    input  logic [NSRC-1:0] pend_src,
    input  logic            pend_cmd,
    output logic [DW-1:0]   rdata,
    output logic [NSRC-1:0] clr_src,
    output logic            clr_cmd,
    output logic            irq
);

    localparam logic [AW-1:0] A_MASK    = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_CLR_CMD = AW'(OFF_CLR_CMD);

    logic [MASK_W-1:0] mask_q;
    logic              mask_hit;

    assign mask_hit = wr && (addr == A_MASK);
    assign clr_cmd  = wr && (addr == A_CLR_CMD);

    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        assign clr_src[g] = wr && (addr == AW'(CLR_OFF[g]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (mask_hit) mask_q <= wdata[MASK_W-1:0];
    end

    always_comb begin
        rdata = '0;
        if (addr == A_MASK) begin
            rdata[RB_FM_BIT]  = fm;
            rdata[RB_EN_BIT]  = 1'b1;
            rdata[MASK_W-1:0] = mask_q;
        end
    end

    always_comb begin
        irq = pend_src[SRC_VRES]
            | (pend_src[SRC_PWM] & mask_q[MB_PWM])
            | (pend_cmd          & mask_q[MB_CMD])
            | (pend_src[SRC_HBL] & mask_q[MB_HBL])
            | (pend_src[SRC_VBL] & mask_q[MB_VBL]);
    end

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_hit |=> (mask_q == $past(wdata[MASK_W-1:0])));

    p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_hit |=> $stable(mask_q));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int AW   = 6,
    parameter int DW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [7:0]          host_data,
    input  logic                adapter_fm,
    input  logic [NSRC-1:0]     src_set,
    input  logic [NCPU-1:0]     cpu_wr,
    input  logic [NCPU*AW-1:0]  cpu_addr,
    input  logic [NCPU*DW-1:0]  cpu_wdata,
    output logic [NCPU*DW-1:0]  cpu_rdata,
    output logic [NCPU-1:0]     cpu_irq
);

    logic [NSRC-1:0] clr_src_by_cpu [NCPU];
    logic [NSRC-1:0] clr_src_any;
    logic [NSRC-1:0] pend_src;
    logic [NCPU-1:0] clr_cmd;
    logic [NCPU-1:0] set_cmd;
    logic [NCPU-1:0] pend_cmd;

    always_comb begin
        clr_src_any = '0;
        for (int c = 0; c < NCPU; c++) clr_src_any |= clr_src_by_cpu[c];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        irqc_src_latch u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_set[s]),
            .clr_i  (clr_src_any[s]),
            .pend_o (pend_src[s])
        );
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign set_cmd[c] = host_wr && host_data[c];

        irqc_src_latch u_cmd (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_cmd[c]),
            .clr_i  (clr_cmd[c]),
            .pend_o (pend_cmd[c])
        );

        irqc_cpu_port #(.AW(AW), .DW(DW)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (cpu_wr[c]),
            .addr     (cpu_addr[c*AW +: AW]),
            .wdata    (cpu_wdata[c*DW +: DW]),
            .fm       (adapter_fm),
            .pend_src (pend_src),
            .pend_cmd (pend_cmd[c]),
            .rdata    (cpu_rdata[c*DW +: DW]),
            .clr_src  (clr_src_by_cpu[c]),
            .clr_cmd  (clr_cmd[c]),
            .irq      (cpu_irq[c])
        );

        p_host_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_data[c]) |=> pend_cmd[c]);

        p_own_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_wr[c] && cpu_addr[c*AW +: AW] == AW'(OFF_CLR_CMD) && !(host_wr && host_data[c]))
            |=> !pend_cmd[c]);

        p_vres_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pend_src[SRC_VRES] |-> cpu_irq[c]);
    end

    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_src == '0 && pend_cmd == '0));

endmodule

// File: tb/dual_irq_ctrl_tb_top.sv
module dual_irq_ctrl_tb_top;

    localparam int NCPU = 2;
    localparam int AW   = 6;
    localparam int DW   = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic host_wr;
    logic [7:0] host_data;
    logic adapter_fm;
    logic [3:0] src_set;
    logic [NCPU-1:0] cpu_wr;
    logic [AW-1:0] a [NCPU];
    logic [DW-1:0] wd [NCPU];
    logic [NCPU*AW-1:0] cpu_addr;
    logic [NCPU*DW-1:0] cpu_wdata;
    logic [NCPU*DW-1:0] cpu_rdata;
    logic [NCPU-1:0] cpu_irq;

    assign cpu_addr  = {a[1], a[0]};
    assign cpu_wdata = {wd[1], wd[0]};

    always #5 clk = ~clk;

    dual_irq_ctrl #(.NCPU(NCPU), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .adapter_fm(adapter_fm), .src_set(src_set), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_irq(cpu_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic [3:0] m_src;
    logic [1:0] m_cmd;
    logic [3:0] m_mask [NCPU];

    function automatic logic exp_irq(int c);
        return m_src[0] | (m_src[3] & m_mask[c][0]) | (m_cmd[c] & m_mask[c][1])
             | (m_src[2] & m_mask[c][2]) | (m_src[1] & m_mask[c][3]);
    endfunction

    function automatic logic [15:0] exp_rd(int c);
        logic [15:0] v = '0;
        if (a[c] == 6'h00) begin
            v[15] = adapter_fm;
            v[9]  = 1'b1;
            v[3:0] = m_mask[c];
        end
        return v;
    endfunction

    function automatic logic [5:0] clr_addr(int s);
        case (s)
            0: return 6'h14;
            1: return 6'h16;
            2: return 6'h18;
            default: return 6'h1C;
        endcase
    endfunction

    task automatic model_update();
        for (int s = 0; s < 4; s++) begin
            logic clr = 1'b0;
            for (int c = 0; c < NCPU; c++)
                if (cpu_wr[c] && a[c] == clr_addr(s)) clr = 1'b1;
            if (src_set[s]) m_src[s] = 1'b1;
            else if (clr)   m_src[s] = 1'b0;
        end
        for (int c = 0; c < NCPU; c++) begin
            if (host_wr && host_data[c]) m_cmd[c] = 1'b1;
            else if (cpu_wr[c] && a[c] == 6'h1A) m_cmd[c] = 1'b0;
            if (cpu_wr[c] && a[c] == 6'h00) m_mask[c] = wd[c][3:0];
        end
    endtask

    task automatic check_outputs(string tag);
        for (int c = 0; c < NCPU; c++) begin
            checks++;
            if (cpu_irq[c] !== exp_irq(c)) begin
                fails++;
                $display("FAIL %s cpu%0d irq actual=%0b expected=%0b", tag, c, cpu_irq[c], exp_irq(c));
            end
            checks++;
            if (cpu_rdata[c*DW +: DW] !== exp_rd(c)) begin
                fails++;
                $display("FAIL %s cpu%0d rdata actual=%h expected=%h", tag, c, cpu_rdata[c*DW +: DW], exp_rd(c));
            end
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_data = 0; src_set = 0; cpu_wr = 0;
        for (int c = 0; c < NCPU; c++) begin a[c] = 6'h00; wd[c] = '0; end
    endtask

    // inputs already driven at a negedge; apply one edge, update model, check
    task automatic step(string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_outputs(tag);
        idle_inputs();
    endtask

    task automatic cpu_write(int c, logic [5:0] ad, logic [15:0] d);
        cpu_wr[c] = 1'b1; a[c] = ad; wd[c] = d;
    endtask

    initial begin
        void'($urandom(32'h1D5C_0A77));
        rst_n = 0; adapter_fm = 0;
        idle_inputs();
        m_src = '0; m_cmd = '0; m_mask[0] = '0; m_mask[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check_outputs("R1 reset state");

        // R6: mask load, upper bits ignored, other cpu untouched
        cpu_write(0, 6'h00, 16'hFFFA); step("R6 mask low nibble");
        cpu_write(1, 6'h00, 16'h0012); step("R6 mask cpu1");
        // R7: fm bit and non-zero offset readback
        adapter_fm = 1; a[1] = 6'h02; @(negedge clk); check_outputs("R7 readback");
        adapter_fm = 0;
        // enable cmd on both
        cpu_write(0, 6'h00, 16'h0002); cpu_write(1, 6'h00, 16'h0002); step("R6 mask cmd");
        // R2: bit0 only, upper bits ignored
        host_wr = 1; host_data = 8'hFD; step("R2 master raise");
        host_wr = 1; host_data = 8'hFC; step("R2 upper bits ignored");
        // R3: raise again then single clear
        host_wr = 1; host_data = 8'h01; step("R3 re-raise");
        cpu_write(0, 6'h1A, 16'h0); step("R3 single clear");
        // R5: own clear only
        host_wr = 1; host_data = 8'h03; step("R2 both raise");
        cpu_write(1, 6'h1A, 16'h0); step("R5 own clear only");
        cpu_write(0, 6'h1A, 16'h0); step("R5 master clear");
        // R10 / R4: vertical set, cleared by cpu1
        cpu_write(0, 6'h00, 16'h0008); step("R6 enable vertical");
        src_set = 4'b0010; step("R10 vertical latched");
        step("R10 vertical held");
        cpu_write(1, 6'h16, 16'h0); step("R4 clear from other cpu");
        // R8: reset-button ignores mask
        cpu_write(0, 6'h00, 16'h0000); cpu_write(1, 6'h00, 16'h0000); step("R8 masks off");
        src_set = 4'b0001; step("R8 reset-button unmasked");
        cpu_write(0, 6'h14, 16'h0); step("R4 clear reset-button");
        // R9: set wins over same-cycle clear
        cpu_write(0, 6'h00, 16'h0004); step("R6 enable horizontal");
        src_set = 4'b0100; cpu_write(0, 6'h18, 16'h0); step("R9 set beats clear");
        host_wr = 1; host_data = 8'h02; cpu_write(1, 6'h1A, 16'h0); step("R9 cmd set beats clear");
        cpu_write(1, 6'h00, 16'h0003); step("R9 cmd still pending");
        cpu_write(0, 6'h18, 16'h0); step("R4 clear horizontal");
        src_set = 4'b1000; cpu_write(1, 6'h00, 16'h0001); step("R10 pwm set");
        cpu_write(1, 6'h1C, 16'h0); step("R4 clear pwm");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            src_set    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
            host_wr    = ($urandom_range(0, 5) == 0);
            host_data  = 8'($urandom);
            adapter_fm = 1'($urandom);
            for (int c = 0; c < NCPU; c++) begin
                logic [5:0] pick [7] = '{6'h00, 6'h14, 6'h16, 6'h18, 6'h1A, 6'h1C, 6'h02};
                cpu_wr[c] = ($urandom_range(0, 2) == 0);
                a[c]      = pick[$urandom_range(0, 6)];
                wd[c]     = 16'($urandom);
            end
            step("R7/R8 random");
        end

        // reset again mid-run: R1
        rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1; adapter_fm = 0;
        m_src = '0; m_cmd = '0; m_mask[0] = '0; m_mask[1] = '0;
        @(negedge clk);
        check_outputs("R1 reset after traffic");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule